// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block keeps the reservation state behind load-exclusive and store-exclusive pairs in a shared-memory system with several processors. Each processor has two trackers. The first is a private reservation flag. Every executed load-exclusive sets it, whatever the memory attributes. The second is a shared-region entry. A load-exclusive to shareable memory fills it with the physical address and the access size. Byte, halfword, word and doubleword exclusives all use the same two trackers, and any address is accepted. Nothing is checked for alignment.

Requests arrive one per cycle on a single port. Each request carries an operation, a condition flag, a shareable attribute, an address that is already translated, a size code and the requesting processor's identifier. A store-exclusive is answered one cycle later with a done pulse and a status bit, where 0 means success and 1 means failure. On success it also raises the memory write enable. An ordinary store raises the write enable and snoops the shared entries of all the other processors. A store that lands inside another processor's reserved span cancels that reservation.

Top module: `excl_monitor_pair`

## Requirements
- R1: After reset every private flag and every shared entry is open, and `sx_done`, `sx_status` and `mem_we` are 0. The first store-exclusive of any processor therefore fails.
- R2: A request whose `req_cond` is 0, whatever its operation, changes no tracker state and produces no output pulse.
- R3: An executed load-exclusive (`req_op`=0) sets the requesting processor's private flag, both for shareable and for non-shareable addresses.
- R4: A shareable load-exclusive also fills the requester's shared entry with the address and size. A shareable store-exclusive then succeeds only if that entry is valid and holds the same address.
- R5: A store-exclusive (`req_op`=1) gives `sx_done`=1 in the cycle after the request. If the private flag is set (and, for a shareable request, R4 also holds), then `sx_status`=0 and `mem_we`=1. Otherwise `sx_status`=1 and `mem_we`=0.
- R6: Every executed store-exclusive, whether it succeeds or fails, clears the requester's private flag and shared entry, so an immediate second store-exclusive fails.
- R7: A clear-exclusive (`req_op`=2) clears the requester's private flag.
- R8: An executed ordinary store (`req_op`=3) from processor P clears the shared entry of every other processor Q whose span holds the store address. The span runs from the base address to the base plus 2^size-1, with size codes 0=1, 1=2, 2=4 and 3=8 bytes. A store outside the span, or a store from Q itself, leaves Q's entry intact.
- R9: A new load-exclusive replaces the earlier reservation of the same processor, so only the latest address is honoured.
- R10: Byte exclusives use the same trackers as wider ones and accept unaligned addresses. A byte reservation at an odd address is satisfied by a store-exclusive of any size at that address, and its span covers exactly one byte.
- R11: The trackers of different processors are independent. Exclusive operations of one processor never change another processor's flag or entry.
- R12: An executed ordinary store gives `mem_we`=1 and `sx_done`=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 load-exclusive, 1 store-exclusive, 2 clear-exclusive, 3 ordinary store |
| req_cond | input | 1 | Condition passed; when 0 the request has no effect |
| req_shared | input | 1 | Address is in shareable memory |
| req_addr | input | ADDR_W | Translated physical address |
| req_size | input | SIZE_W | Access size code, span 2^code bytes |
| req_pid | input | PID_W | Requesting processor identifier |
| sx_done | output | 1 | Store-exclusive result valid (one cycle after request) |
| sx_status | output | 1 | 0 success, 1 failure; meaningful while sx_done is 1 |
| mem_we | output | 1 | Write enable for the memory store |

## Verification
The bench aims at the snoop span edges: the last byte inside a word span, the first byte past it, a byte just below the base, and a one-byte span at an odd base. A design with an off-by-one range would cancel reservations it should keep, or keep ones it should cancel. It checks that a failed store-exclusive still closes both trackers, because a design that only clears on success would let a second attempt succeed. It also checks that a condition-failed request leaves an armed flag intact, that the same processor's own store never cancels its reservation, and that one processor's clear or store-exclusive cannot close another's. A long random run is compared against the behavioural model on every cycle.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_LDX   = 2'd0,
    OP_STX   = 2'd1,
    OP_CLRX  = 2'd2,
    OP_STORE = 2'd3
  } excl_op_e;
endpackage

// File: rtl/excl_local_flag.sv
module excl_local_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic close_i,
  output logic armed_o
);
  logic armed_q;
  logic armed_d;

  always_comb begin
    armed_d = armed_q;
    if (close_i) armed_d = 1'b0;
    if (arm_i)   armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign armed_o = armed_q;

  p_arm_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> armed_o);

  p_close_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (close_i && !arm_i) |=> !armed_o);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!close_i && !arm_i) |=> $stable(armed_o));
endmodule

// File: rtl/excl_shared_entry.sv
module excl_shared_entry #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              drop_i,
  input  logic              snoop_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  output logic              valid_o,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] base_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] offset;
  logic              in_span;

  assign span    = ONE << size_q;
  assign offset  = req_addr_i - base_q;
  assign in_span = offset < span;

  always_comb begin
    valid_d = valid_q;
    if (drop_i || (snoop_i && in_span)) valid_d = 1'b0;
    if (arm_i) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else if (arm_i) begin
      base_q <= req_addr_i;
      size_q <= req_size_i;
    end
  end

  assign valid_o = valid_q;
  assign hit_o   = valid_q && (req_addr_i == base_q);

  p_arm_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> valid_o);

  p_drop_on_stx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_i && !arm_i) |=> !valid_o);

  p_snoop_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_i && in_span && !arm_i) |=> !valid_o);

  p_base_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> $stable(base_q));
endmodule

// File: rtl/excl_monitor_pair.sv
module excl_monitor_pair
  import excl_mon_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 2,
  localparam int PID_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_cond,
  input  logic              req_shared,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [PID_W-1:0]  req_pid,
  output logic              sx_done,
  output logic              sx_status,
  output logic              mem_we
);
  excl_op_e op;
  logic     go;
  logic     go_ldx, go_stx, go_clr, go_st;

  assign op     = excl_op_e'(req_op);
  assign go     = req_valid && req_cond;
  assign go_ldx = go && (op == OP_LDX);
  assign go_stx = go && (op == OP_STX);
  assign go_clr = go && (op == OP_CLRX);
  assign go_st  = go && (op == OP_STORE);

  logic [NUM_PROC-1:0] flag_armed;
  logic [NUM_PROC-1:0] entry_hit;
  logic [NUM_PROC-1:0] entry_valid;

  for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
    logic is_me;
    assign is_me = (req_pid == PID_W'(p));

    excl_local_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_i   (go_ldx && is_me),
      .close_i ((go_stx || go_clr) && is_me),
      .armed_o (flag_armed[p])
    );

    excl_shared_entry #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (go_ldx && req_shared && is_me),
      .drop_i     (go_stx && is_me),
      .snoop_i    (go_st && !is_me),
      .req_addr_i (req_addr),
      .req_size_i (req_size),
      .valid_o    (entry_valid[p]),
      .hit_o      (entry_hit[p])
    );
  end

  logic sel_armed, sel_hit, sx_ok;

  always_comb begin
    sel_armed = 1'b0;
    sel_hit   = 1'b0;
    for (int i = 0; i < NUM_PROC; i++) begin
      if (req_pid == PID_W'(i)) begin
        sel_armed = flag_armed[i];
        sel_hit   = entry_hit[i];
      end
    end
  end

  assign sx_ok = sel_armed && (!req_shared || sel_hit);

  logic done_d, status_d, we_d;
  logic done_q, status_q, we_q;

  always_comb begin
    done_d   = go_stx;
    status_d = go_stx && !sx_ok;
    we_d     = (go_stx && sx_ok) || go_st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      status_q <= 1'b0;
      we_q     <= 1'b0;
    end else begin
      done_q   <= done_d;
      status_q <= status_d;
      we_q     <= we_d;
    end
  end

  assign sx_done   = done_q;
  assign sx_status = status_q;
  assign mem_we    = we_q;

  p_unarmed_fails_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_stx && !sel_armed) |=> (sx_done && sx_status && !mem_we));

  p_success_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sx_done && !sx_status) |-> mem_we);

  p_store_no_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    go_st |=> (mem_we && !sx_done));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (!sx_done && !mem_we));

  p_entry_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go_stx && req_shared && !sel_hit) |=> sx_status);
endmodule

// File: tb/excl_monitor_pair_bench.sv
module excl_monitor_pair_bench;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic        req_cond;
  logic        req_shared;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [1:0]  req_pid;
  logic        sx_done, sx_status, mem_we;

  always #4 clk = ~clk;

  excl_monitor_pair u_excl_monitor_pair (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_cond(req_cond), .req_shared(req_shared), .req_addr(req_addr),
    .req_size(req_size), .req_pid(req_pid), .sx_done(sx_done),
    .sx_status(sx_status), .mem_we(mem_we)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  bit          m_flag [NP];
  bit          m_gv   [NP];
  logic [31:0] m_ga   [NP];
  int          m_gs   [NP];

  bit    e_done, e_stat, e_we;
  string e_tag = "R1";

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic compare_now();
    compared++;
    if (sx_done !== e_done || sx_status !== e_stat || mem_we !== e_we) begin
      mismatched++;
      $display("FAIL %s: done/status/we actual %b%b%b expected %b%b%b",
               e_tag, sx_done, sx_status, mem_we, e_done, e_stat, e_we);
    end
  endtask

  task automatic step(input bit v, input int op, input bit cond, input bit sh,
                      input logic [31:0] addr, input int size, input int pid,
                      input string tag);
    bit ok;
    @(negedge clk);
    compare_now();
    e_done = 0; e_stat = 0; e_we = 0; e_tag = tag;
    if (v && cond) begin
      case (op)
        0: begin
          m_flag[pid] = 1;
          if (sh) begin m_gv[pid] = 1; m_ga[pid] = addr; m_gs[pid] = size; end
        end
        1: begin
          ok = m_flag[pid] && (!sh || (m_gv[pid] && m_ga[pid] == addr));
          e_done = 1; e_stat = !ok; e_we = ok;
          m_flag[pid] = 0; m_gv[pid] = 0;
        end
        2: m_flag[pid] = 0;
        default: begin
          e_we = 1;
          for (int q = 0; q < NP; q++)
            if (q != pid && m_gv[q] && addr >= m_ga[q] &&
                addr <= m_ga[q] + (32'd1 << m_gs[q]) - 32'd1)
              m_gv[q] = 0;
        end
      endcase
    end
    req_valid = v; req_op = 2'(op); req_cond = cond; req_shared = sh;
    req_addr = addr; req_size = 2'(size); req_pid = 2'(pid);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 32'h0, 0, 0, tag);
  endtask

  initial begin
    req_valid = 0; req_op = 0; req_cond = 0; req_shared = 0;
    req_addr = 0; req_size = 0; req_pid = 0;
    for (int i = 0; i < NP; i++) begin m_flag[i] = 0; m_gv[i] = 0; m_ga[i] = 0; m_gs[i] = 0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare_now();               // R1 outputs quiet in reset
    rst_n = 1;
    // R1: store-exclusive straight after reset fails, for every processor
    for (int p = 0; p < NP; p++) step(1, 1, 1, p[0], 32'h40, 2, p, "R1");
    // R3/R5: non-shared reservation then success
    step(1, 0, 1, 0, 32'h100, 2, 0, "R3");
    step(1, 1, 1, 0, 32'h100, 2, 0, "R5");
    // R6: second attempt fails
    step(1, 1, 1, 0, 32'h100, 2, 0, "R6");
    // R4: shared, address mismatch fails; match succeeds
    step(1, 0, 1, 1, 32'h200, 2, 1, "R4");
    step(1, 1, 1, 1, 32'h204, 2, 1, "R4");
    step(1, 0, 1, 1, 32'h200, 2, 1, "R4");
    step(1, 1, 1, 1, 32'h200, 2, 1, "R4");
    // R6: failed shared attempt still closes both trackers
    step(1, 0, 1, 1, 32'h220, 2, 1, "R6");
    step(1, 1, 1, 1, 32'h224, 2, 1, "R6");
    step(1, 1, 1, 1, 32'h220, 2, 1, "R6");
    // R2: condition-failed requests do nothing
    step(1, 0, 0, 1, 32'h280, 2, 2, "R2");
    step(1, 1, 1, 0, 32'h280, 2, 2, "R2");
    step(1, 0, 1, 1, 32'h280, 2, 2, "R2");
    step(1, 1, 0, 1, 32'h280, 2, 2, "R2");
    step(1, 2, 0, 0, 32'h280, 2, 2, "R2");
    step(1, 3, 0, 0, 32'h280, 2, 0, "R2");
    step(1, 1, 1, 1, 32'h280, 2, 2, "R2");
    // R7: clear-exclusive
    step(1, 0, 1, 0, 32'h2C0, 2, 3, "R7");
    step(1, 2, 1, 0, 32'h2C0, 2, 3, "R7");
    step(1, 1, 1, 0, 32'h2C0, 2, 3, "R7");
    // R8: snoop span edges for a word reservation at 0x300
    step(1, 0, 1, 1, 32'h300, 2, 0, "R8");
    step(1, 3, 1, 1, 32'h303, 2, 1, "R8");
    step(1, 1, 1, 1, 32'h300, 2, 0, "R8");
    step(1, 0, 1, 1, 32'h300, 2, 0, "R8");
    step(1, 3, 1, 1, 32'h304, 2, 1, "R8");
    step(1, 3, 1, 1, 32'h2FF, 0, 2, "R8");
    step(1, 3, 1, 1, 32'h300, 2, 0, "R8");
    step(1, 1, 1, 1, 32'h300, 2, 0, "R8");
    // R9: latest reservation wins
    step(1, 0, 1, 1, 32'h400, 2, 1, "R9");
    step(1, 0, 1, 1, 32'h500, 2, 1, "R9");
    step(1, 1, 1, 1, 32'h400, 2, 1, "R9");
    step(1, 0, 1, 1, 32'h400, 2, 1, "R9");
    step(1, 0, 1, 1, 32'h500, 2, 1, "R9");
    step(1, 1, 1, 1, 32'h500, 2, 1, "R9");
    // R10: unaligned byte reservation, one-byte span
    step(1, 0, 1, 1, 32'h603, 0, 2, "R10");
    step(1, 3, 1, 1, 32'h604, 0, 0, "R10");
    step(1, 1, 1, 1, 32'h603, 2, 2, "R10");
    step(1, 0, 1, 1, 32'h603, 0, 2, "R10");
    step(1, 3, 1, 1, 32'h603, 0, 0, "R10");
    step(1, 1, 1, 1, 32'h603, 0, 2, "R10");
    // R11: independence between processors
    step(1, 0, 1, 1, 32'h700, 2, 0, "R11");
    step(1, 0, 1, 1, 32'h700, 2, 1, "R11");
    step(1, 1, 1, 1, 32'h700, 2, 1, "R11");
    step(1, 2, 1, 0, 32'h700, 2, 3, "R11");
    step(1, 1, 1, 1, 32'h700, 2, 0, "R11");
    // R12: ordinary store
    step(1, 3, 1, 0, 32'h800, 1, 3, "R12");
    idle("R12");
    // Random run against the model (R5, R8 mix)
    for (int k = 0; k < 600; k++)
      step(($urandom % 5) != 0, int'($urandom % 4), ($urandom % 6) != 0,
           bit'($urandom % 2), 32'h1000 + ($urandom % 12),
           int'($urandom % 4), int'($urandom % 4), "R5");
    idle("R5");
    idle("R2");
    @(negedge clk);
    compare_now();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule